// File: doc/BRIEF.md
# FIFO Level Interrupt and DMA Request Unit

This unit watches the transmit and receive FIFO fill levels of a serial controller and turns them into status flags, interrupt flags and DMA requests. The FIFO storage and the register bus live elsewhere. This block takes the two levels, the push and pop strobes of the FIFOs and a busy flag from the shift engine. It also takes register writes through a select code and a data word.

Two kinds of interrupt source are merged into one 5-bit raw word. The first kind is a pair of level-driven threshold flags. The second kind is three sticky error flags, which record an overflow or an underflow. A separate 4-bit clear write removes sticky flags, and its bit order differs from the interrupt word's. A mask selects which raw bits reach the masked word and the single interrupt line. Each DMA direction has an enable bit and a data-level compare of its own.

The threshold registers are read back on output ports. A threshold write of a value at or beyond the FIFO depth is dropped, so software can find the depth by probing.

Top module: `fifo_lvl_irq`

## Requirements
- R1: The status word is combinational from the inputs. Bit 0 is engine busy. Bit 1 is transmit level equal to DEPTH. Bit 2 is transmit level zero. Bit 3 is receive level zero. Bit 4 is receive level equal to DEPTH.
- R2: Raw interrupt bit 0 (transmit low) is 1 while the transmit level is at or below the transmit threshold.
- R3: Raw interrupt bit 4 (receive high) is 1 while the receive level is strictly above the receive threshold.
- R4: Three sticky raw bits are set on the clock edge after an error event. Bit 1 is set by a transmit push at full level. Bit 2 is set by a receive pop at zero level. Bit 3 is set by a receive push at full level. Each stays set until cleared.
- R5: A write with select 3 clears sticky bits from wdata. Bit 0 clears all three. Bit 1 clears raw bit 2. Bit 2 clears raw bit 3. Bit 3 clears raw bit 1. An error event in the same cycle as a clear wins, so its bit stays set.
- R6: The masked interrupt word equals the raw word ANDed with the 5-bit mask. The mask is written with select 2 from wdata[4:0], and a mask bit of 1 passes the raw bit.
- R7: The interrupt output is 1 exactly when any masked bit is 1.
- R8: Select 0 writes the transmit threshold and select 1 writes the receive threshold. Select 5 writes the transmit data level and select 6 writes the receive data level. A write whose wdata is DEPTH or more leaves the register unchanged. The thresholds read back on their output ports.
- R9: Select 4 writes the DMA enables, with wdata bit 0 for receive and bit 1 for transmit. The transmit request is enable AND (transmit level at or below the transmit data level). The receive request is enable AND (receive level above the receive data level).
- R10: After reset, the thresholds, data levels, mask, DMA enables and sticky bits are all zero. Select 7 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_push | input | 1 | Write into the transmit FIFO |
| rx_push | input | 1 | Write into the receive FIFO |
| rx_pop | input | 1 | Read from the receive FIFO |
| eng_busy | input | 1 | Shift engine busy |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | DATA_W | Register write data |
| status | output | 5 | Status flags |
| raw_irq | output | 5 | Raw interrupt flags |
| masked_irq | output | 5 | Masked interrupt flags |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_thresh | output | THR_W | Transmit threshold readback |
| rx_thresh | output | THR_W | Receive threshold readback |

## Verification
The bench drives levels at exactly zero, exactly DEPTH and equal to each threshold or data level. These cases expose a design that uses the wrong comparison, for example strict where it should be inclusive on the transmit side. It sends each single-bit clear pattern against all three sticky bits set. A design that follows the interrupt bit order for clearing would wipe the wrong flag and leave the intended one set. It also places an error event in the same cycle as its own clear, and a design where the clear wins would lose that event. Threshold and data-level writes at and beyond DEPTH are checked for retention, because a design that truncates the value would store a wrapped threshold.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

  typedef enum logic [2:0] {
    SEL_TX_THR = 3'd0,
    SEL_RX_THR = 3'd1,
    SEL_MASK   = 3'd2,
    SEL_CLEAR  = 3'd3,
    SEL_DMA    = 3'd4,
    SEL_TX_DL  = 3'd5,
    SEL_RX_DL  = 3'd6,
    SEL_NONE   = 3'd7
  } lvl_sel_e;

  localparam int IRQ_W    = 5;
  localparam int IRQ_TXLO = 0;
  localparam int IRQ_TXOV = 1;
  localparam int IRQ_RXUN = 2;
  localparam int IRQ_RXOV = 3;
  localparam int IRQ_RXHI = 4;

  localparam int ST_BUSY  = 0;
  localparam int ST_TXFUL = 1;
  localparam int ST_TXEMP = 2;
  localparam int ST_RXEMP = 3;
  localparam int ST_RXFUL = 4;

  localparam logic [IRQ_W-1:0] STICKY_BITS = 5'b01110;

  // Clear-register order to interrupt-word order.
  function automatic logic [IRQ_W-1:0] clear_map(input logic [3:0] c);
    logic [IRQ_W-1:0] v;
    v = '0;
    if (c[0]) v = v | STICKY_BITS;
    if (c[1]) v[IRQ_RXUN] = 1'b1;
    if (c[2]) v[IRQ_RXOV] = 1'b1;
    if (c[3]) v[IRQ_TXOV] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/fifo_lvl_regs.sv
module fifo_lvl_regs
  import fifo_lvl_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int THR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [THR_W-1:0]  tx_thr,
  output logic [THR_W-1:0]  rx_thr,
  output logic [THR_W-1:0]  tx_dl,
  output logic [THR_W-1:0]  rx_dl,
  output logic [IRQ_W-1:0]  irq_mask,
  output logic [1:0]        dma_en,
  output logic [IRQ_W-1:0]  clr_vec
);
  localparam logic [DATA_W-1:0] DEPTH_D = DATA_W'(DEPTH);
  localparam int N_LVL = 4;
  localparam logic [2:0] LVL_SEL [N_LVL] = '{SEL_TX_THR, SEL_RX_THR, SEL_TX_DL, SEL_RX_DL};

  logic              wdata_fits;
  logic [THR_W-1:0]  lvl_q [N_LVL];

  assign wdata_fits = (reg_wdata < DEPTH_D);

  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_q[i] <= '0;
      else if (reg_wr && (reg_sel == LVL_SEL[i]) && wdata_fits)
        lvl_q[i] <= reg_wdata[THR_W-1:0];
    end
  end

  assign tx_thr = lvl_q[0];
  assign rx_thr = lvl_q[1];
  assign tx_dl  = lvl_q[2];
  assign rx_dl  = lvl_q[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask <= '0;
      dma_en   <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_MASK) irq_mask <= reg_wdata[IRQ_W-1:0];
      if (reg_sel == SEL_DMA)  dma_en   <= reg_wdata[1:0];
    end
  end

  assign clr_vec = (reg_wr && reg_sel == SEL_CLEAR) ? clear_map(reg_wdata[3:0]) : '0;

endmodule

// File: rtl/fifo_lvl_sticky.sv
module fifo_lvl_sticky
  import fifo_lvl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] clr_vec,
  output logic [IRQ_W-1:0] flags
);
  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    if (STICKY_BITS[b]) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flags[b] <= 1'b0;
        else if (set_vec[b]) flags[b] <= 1'b1;
        else if (clr_vec[b]) flags[b] <= 1'b0;
      end
    end else begin : g_none
      assign flags[b] = 1'b0;
    end
  end
endmodule

// File: rtl/fifo_lvl_compare.sv
module fifo_lvl_compare
  import fifo_lvl_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int THR_W = $clog2(DEPTH)
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             eng_busy,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [THR_W-1:0] tx_dl,
  input  logic [THR_W-1:0] rx_dl,
  input  logic [1:0]       dma_en,
  output logic [4:0]       status,
  output logic [IRQ_W-1:0] level_flags,
  output logic [IRQ_W-1:0] err_events,
  output logic             tx_req,
  output logic             rx_req
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  function automatic logic at_or_below(input logic [LVL_W-1:0] lvl, input logic [THR_W-1:0] lim);
    return lvl <= LVL_W'(lim);
  endfunction

  function automatic logic above(input logic [LVL_W-1:0] lvl, input logic [THR_W-1:0] lim);
    return lvl > LVL_W'(lim);
  endfunction

  logic tx_full, tx_empty, rx_full, rx_empty;
  assign tx_full  = (tx_level == FULL);
  assign tx_empty = (tx_level == '0);
  assign rx_full  = (rx_level == FULL);
  assign rx_empty = (rx_level == '0);

  always_comb begin
    status           = '0;
    status[ST_BUSY]  = eng_busy;
    status[ST_TXFUL] = tx_full;
    status[ST_TXEMP] = tx_empty;
    status[ST_RXEMP] = rx_empty;
    status[ST_RXFUL] = rx_full;

    level_flags           = '0;
    level_flags[IRQ_TXLO] = at_or_below(tx_level, tx_thr);
    level_flags[IRQ_RXHI] = above(rx_level, rx_thr);

    err_events           = '0;
    err_events[IRQ_TXOV] = tx_push & tx_full;
    err_events[IRQ_RXUN] = rx_pop & rx_empty;
    err_events[IRQ_RXOV] = rx_push & rx_full;
  end

  assign tx_req = dma_en[1] & at_or_below(tx_level, tx_dl);
  assign rx_req = dma_en[0] & above(rx_level, rx_dl);

endmodule

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq
  import fifo_lvl_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int THR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_push,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              eng_busy,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [4:0]        status,
  output logic [4:0]        raw_irq,
  output logic [4:0]        masked_irq,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic [THR_W-1:0]  tx_thresh,
  output logic [THR_W-1:0]  rx_thresh
);
  logic [THR_W-1:0] tx_dl, rx_dl;
  logic [IRQ_W-1:0] irq_mask, clr_vec, level_flags, err_events, sticky_flags;
  logic [1:0]       dma_en;

  fifo_lvl_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .tx_thr(tx_thresh), .rx_thr(rx_thresh), .tx_dl(tx_dl), .rx_dl(rx_dl),
    .irq_mask(irq_mask), .dma_en(dma_en), .clr_vec(clr_vec)
  );

  fifo_lvl_compare #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
    .tx_level(tx_level), .rx_level(rx_level), .tx_push(tx_push), .rx_push(rx_push),
    .rx_pop(rx_pop), .eng_busy(eng_busy), .tx_thr(tx_thresh), .rx_thr(rx_thresh),
    .tx_dl(tx_dl), .rx_dl(rx_dl), .dma_en(dma_en), .status(status),
    .level_flags(level_flags), .err_events(err_events), .tx_req(tx_dma_req), .rx_req(rx_dma_req)
  );

  fifo_lvl_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(err_events), .clr_vec(clr_vec), .flags(sticky_flags)
  );

  assign raw_irq    = level_flags | sticky_flags;
  assign masked_irq = raw_irq & irq_mask;
  assign irq        = |masked_irq;

endmodule

// File: rtl/fifo_lvl_irq_chk.sv
module fifo_lvl_irq_chk #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int THR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [4:0]        err_events,
  input logic [4:0]        clr_vec,
  input logic [4:0]        raw_irq,
  input logic [4:0]        masked_irq,
  input logic              irq,
  input logic              tx_dma_req,
  input logic [THR_W-1:0]  tx_thresh
);
  localparam logic [DATA_W-1:0] DEPTH_D = DATA_W'(DEPTH);

  p_txov_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_events[1] |=> raw_irq[1]);

  p_rxun_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_irq[2] && !clr_vec[2]) |=> raw_irq[2]);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd3 && reg_wdata[3] && !err_events[1]) |=> !raw_irq[1]);

  p_masked_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_irq & ~raw_irq) == 5'd0);

  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_irq != 5'd0));

  p_thr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd0 && reg_wdata >= DEPTH_D) |=> $stable(tx_thresh));

  p_dma_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd4 && !reg_wdata[1]) |=> !tx_dma_req);

endmodule

bind fifo_lvl_irq fifo_lvl_irq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .err_events(err_events), .clr_vec(clr_vec), .raw_irq(raw_irq), .masked_irq(masked_irq),
  .irq(irq), .tx_dma_req(tx_dma_req), .tx_thresh(tx_thresh)
);

// File: tb/tb_fifo_lvl_irq.sv
module tb_fifo_lvl_irq;
  localparam int CLK_PERIOD = 10;
  localparam int D     = 32;
  localparam int DW    = 8;
  localparam int LW    = $clog2(D + 1);
  localparam int TW    = $clog2(D);

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] tx_level = 0, rx_level = 0;
  logic tx_push = 0, rx_push = 0, rx_pop = 0, eng_busy = 0, reg_wr = 0;
  logic [2:0] reg_sel = 3'd7;
  logic [DW-1:0] reg_wdata = 0;
  logic [4:0] status, raw_irq, masked_irq;
  logic irq, tx_dma_req, rx_dma_req;
  logic [TW-1:0] tx_thresh, rx_thresh;

  fifo_lvl_irq #(.DEPTH(D), .DATA_W(DW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_txthr = 0, m_rxthr = 0, m_txdl = 0, m_rxdl = 0, m_mask = 0, m_dma = 0;
  bit m_txov = 0, m_rxun = 0, m_rxov = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int tl = int'(tx_level), rl = int'(rx_level);
    int st, raw, msk;
    st = (eng_busy ? 1 : 0) + (tl == D ? 2 : 0) + (tl == 0 ? 4 : 0) + (rl == 0 ? 8 : 0) + (rl == D ? 16 : 0);
    raw = (tl <= m_txthr ? 1 : 0) + (m_txov ? 2 : 0) + (m_rxun ? 4 : 0) + (m_rxov ? 8 : 0) + (rl > m_rxthr ? 16 : 0);
    msk = raw & m_mask;
    chk("R1 status", int'(status), st);
    chk("R2/R3/R4 raw_irq", int'(raw_irq), raw);
    chk("R6 masked_irq", int'(masked_irq), msk);
    chk("R7 irq", int'(irq), msk != 0 ? 1 : 0);
    chk("R9 tx_dma_req", int'(tx_dma_req), ((m_dma & 2) != 0 && tl <= m_txdl) ? 1 : 0);
    chk("R9 rx_dma_req", int'(rx_dma_req), ((m_dma & 1) != 0 && rl > m_rxdl) ? 1 : 0);
    chk("R8 tx_thresh", int'(tx_thresh), m_txthr);
    chk("R8 rx_thresh", int'(rx_thresh), m_rxthr);
  endtask

  task automatic model_update();
    int tl = int'(tx_level), rl = int'(rx_level), w = int'(reg_wdata);
    bit s_txov = tx_push && tl == D;
    bit s_rxun = rx_pop && rl == 0;
    bit s_rxov = rx_push && rl == D;
    if (reg_wr) begin
      case (reg_sel)
        3'd0: if (w < D) m_txthr = w;
        3'd1: if (w < D) m_rxthr = w;
        3'd2: m_mask = w & 31;
        3'd3: begin
          if ((w & 1) != 0) begin m_txov = 0; m_rxun = 0; m_rxov = 0; end
          if ((w & 2) != 0) m_rxun = 0;
          if ((w & 4) != 0) m_rxov = 0;
          if ((w & 8) != 0) m_txov = 0;
        end
        3'd4: m_dma = w & 3;
        3'd5: if (w < D) m_txdl = w;
        3'd6: if (w < D) m_rxdl = w;
        default: ;
      endcase
    end
    if (s_txov) m_txov = 1;
    if (s_rxun) m_rxun = 1;
    if (s_rxov) m_rxov = 1;
  endtask

  task automatic step();
    #1 compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
    reg_wr = 0; tx_push = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic wr(int sel, int data);
    reg_wr = 1; reg_sel = 3'(sel); reg_wdata = DW'(data);
    step();
  endtask

  task automatic lv(int t, int r);
    tx_level = LW'(t); rx_level = LW'(r);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10: reset state (model all zero)
    lv(5, 5);
    #1 compare_all();
    @(negedge clk);
    rst_n = 1;
    step();
    // R10: select 7 writes nothing
    wr(7, 3); step();
    // R8: threshold writes, in range and out of range
    wr(0, 10); wr(1, 12); step();
    chk("R8 tx_thresh after write 10", int'(tx_thresh), 10);
    wr(0, D); wr(0, D + 5); wr(1, 255); step();
    chk("R8 rx_thresh kept after 255", int'(rx_thresh), 12);
    wr(0, D - 1); step();
    // R2/R3: boundaries at thresholds
    wr(2, 31);
    lv(D - 1, 12); step(); lv(D, 13); step(); lv(0, 0); step(); lv(D - 2, D); step();
    // R4: error events
    lv(D, 0); tx_push = 1; rx_pop = 1; step();
    lv(5, D); rx_push = 1; step();
    chk("R4 all sticky set", int'(raw_irq[3:1]), 7);
    // R5: each single-bit clear
    wr(3, 2); chk("R5 clear bit1 -> raw bit2", int'(raw_irq[2]), 0);
    wr(3, 4); chk("R5 clear bit2 -> raw bit3", int'(raw_irq[3]), 0);
    wr(3, 8); chk("R5 clear bit3 -> raw bit1", int'(raw_irq[1]), 0);
    lv(D, D); tx_push = 1; rx_push = 1; step();
    lv(3, 0); rx_pop = 1; step();
    wr(3, 1); chk("R5 clear all", int'(raw_irq[3:1]), 0);
    // R5: event in the same cycle as its clear survives
    lv(D, 4); tx_push = 1; reg_wr = 1; reg_sel = 3'd3; reg_wdata = 8'd9; step();
    chk("R5 set beats clear", int'(raw_irq[1]), 1);
    wr(3, 1);
    // R6/R7: mask patterns
    wr(2, 0); step(); wr(2, 16); lv(0, 20); step(); wr(2, 1); step();
    // R9: DMA
    wr(5, 8); wr(6, 20); wr(4, 3);
    lv(8, 20); step(); lv(9, 21); step(); lv(0, D); step();
    wr(4, 1); step(); wr(4, 2); step(); wr(5, D); step();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom % 6;
      tx_level = LW'(k == 0 ? 0 : (k == 1 ? D : $urandom_range(D, 0)));
      k = $urandom % 6;
      rx_level = LW'(k == 0 ? 0 : (k == 1 ? D : $urandom_range(D, 0)));
      tx_push = ($urandom % 3) == 0; rx_push = ($urandom % 3) == 0;
      rx_pop = ($urandom % 3) == 0; eng_busy = ($urandom % 2) == 0;
      if ($urandom % 3 == 0) begin
        reg_wr = 1; reg_sel = 3'($urandom % 8); reg_wdata = DW'($urandom % 48);
      end
      step();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule